// File: doc/BRIEF.md
# Slot-Selectable Stereo Serial Audio Transmitter

This block places a stereo pair of 20-bit PCM samples on a shared serial data line. The bit clock and word clock come from an external master. A 3-bit mode input selects the frame layout. In the two-channel layout, each half of the word-clock period carries one channel. In the four multi-slot layouts, a frame is eight 32-bit slots long and the block owns one adjacent pair of those slots. Outside the bits it owns, the block drops its output enable so that a pad driver can release the line. Up to four transmitters can then share one line, each owning a different slot pair.

All state is updated on the falling edge of the bit clock, so the data and enable outputs only change just after that edge. The samples for a frame are captured at the edge that starts the frame. A source can therefore update its sample registers at any time without corrupting a frame in flight. The count of bit clocks per word clock is not configured: every word-clock edge restarts the bit position. Ratios from 64 to 512 bit clocks per frame therefore work without setup.

Top module: `serial_slot_tx`

## Requirements
- R1: While reset is asserted, `sdata_oe_o` and `sdata_o` are 0. After reset, neither output is driven until the first word-clock edge that starts a channel or frame. The word-clock value seen at the first falling bit-clock edge after reset is only recorded as the reference level; it is not treated as an edge.
- R2: The mode encoding is as follows. Mode 0 selects the two-channel layout. Mode m, for m from 1 to 4, selects the multi-slot layout owning slots 2m-1 and 2m, counting slots from 1. Modes 5 to 7 never assert `sdata_oe_o`.
- R3: In mode 0, each word-clock transition is followed after one bit clock by the MSB of a channel. The channel is the left sample when the word clock is 0 and the right sample when it is 1. The 20 bits follow MSB first, one per bit clock.
- R4: In mode 0, `sdata_oe_o` is 0 from the 21st bit clock of each half-frame until the next word-clock transition. This holds for 64, 128, 192, 256, 384 and 512 bit clocks per frame.
- R5: In modes 1 to 4, a rising word-clock edge starts a frame, and the first bit of slot 1 is sent one bit clock after it. Slot k (from 1) occupies frame bit positions 32(k-1) to 32k-1.
- R6: In modes 1 to 4, the first slot of the owned pair carries the left sample and the second slot carries the right sample. Each sample occupies the slot's first 20 bits, MSB first. `sdata_oe_o` is 0 for the remaining 12 bits of each owned slot, in every other slot, and past bit position 255 of a longer frame.
- R7: Samples are captured at frame start: the falling word-clock edge in mode 0, the rising edge in modes 1 to 4. Changes to `left_i` or `right_i` after that edge do not affect the bits of that frame.
- R8: `sdata_o` and `sdata_oe_o` change only on falling edges of `bclk`. A change on any input between falling edges leaves them unchanged.
- R9: Whenever `sdata_oe_o` is 0, `sdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all state updates on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lrclk | input | 1 | Word clock from the master |
| mode | input | 3 | Layout and slot-pair select (see R2) |
| left_i | input | 20 | Left PCM sample, two's complement |
| right_i | input | 20 | Right PCM sample, two's complement |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe_o | output | 1 | Drive enable for the shared data line |

## Verification
The assertions assume that the word clock and mode change only between falling bit-clock edges. They also assume that mode stays constant for at least one bit clock around the edges they relate. The edge-to-MSB property further assumes that every half-frame is longer than one bit clock.

The stimulus meets these assumptions in three ways:
- It drives every input half a period away from the falling edge.
- It changes mode only while reset is asserted.
- It uses only frames of 64 bit clocks or more, with the word clock at a 50% duty cycle.

// File: rtl/serial_slot_tx.sv
module serial_slot_tx #(
  parameter int SAMPLE_W = 20,
  parameter int SLOT_W   = 32,
  parameter int SLOTS    = 8,
  parameter int MAX_BITS = 512
) (
  input  logic                bclk,
  input  logic                rst_n,
  input  logic                lrclk,
  input  logic [2:0]          mode,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sdata_o,
  output logic                sdata_oe_o
);
  localparam int CNT_W = $clog2(MAX_BITS);
  localparam int BIT_W = $clog2(SLOT_W);
  localparam int PAIRS = SLOTS / 2;
  localparam int FRAME = SLOT_W * SLOTS;
  localparam logic [CNT_W-1:0] POS_MAX = '1;

  logic                lr_q, primed;
  logic [CNT_W-1:0]    pos_q, pos_n, idx;
  logic [SAMPLE_W-1:0] left_q, right_q, cur_l, cur_r, word, shifted;
  logic                drive;

  wire i2s     = (mode == 3'd0);
  wire tdm     = (int'(mode) >= 1) && (int'(mode) <= PAIRS);
  wire rise    = primed & lrclk & ~lr_q;
  wire fall    = primed & ~lrclk & lr_q;
  wire restart = i2s ? (rise | fall) : rise;
  wire latch   = i2s ? fall : rise;

  wire [CNT_W-BIT_W-1:0] slot = pos_n[CNT_W-1:BIT_W];
  wire [BIT_W-1:0]       bitp = pos_n[BIT_W-1:0];

  assign pos_n = restart ? '0 : (pos_q == POS_MAX ? pos_q : pos_q + 1'b1);
  assign cur_l = latch ? left_i  : left_q;
  assign cur_r = latch ? right_i : right_q;

  always_comb begin
    drive = 1'b0;
    word  = cur_l;
    idx   = pos_n;
    if (i2s) begin
      drive = int'(pos_n) < SAMPLE_W;
      word  = lrclk ? cur_r : cur_l;
    end else if (tdm) begin
      drive = (int'(pos_n) < FRAME) && (int'(slot >> 1) == int'(mode) - 1)
              && (int'(bitp) < SAMPLE_W);
      word  = slot[0] ? cur_r : cur_l;
      idx   = CNT_W'(bitp);
    end
  end

  assign shifted = word << idx;

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q       <= 1'b0;
      primed     <= 1'b0;
      pos_q      <= POS_MAX;
      left_q     <= '0;
      right_q    <= '0;
      sdata_o    <= 1'b0;
      sdata_oe_o <= 1'b0;
    end else begin
      lr_q       <= lrclk;
      primed     <= 1'b1;
      pos_q      <= pos_n;
      sdata_oe_o <= drive;
      sdata_o    <= drive & shifted[SAMPLE_W-1];
      if (latch) begin
        left_q  <= left_i;
        right_q <= right_i;
      end
    end
  end
endmodule

// File: rtl/serial_slot_tx_checker.sv
module serial_slot_tx_checker #(
  parameter int SAMPLE_W = 20
) (
  input logic       bclk,
  input logic       rst_n,
  input logic       lrclk,
  input logic [2:0] mode,
  input logic       sdata_o,
  input logic       sdata_oe_o
);
  logic [7:0] run;

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (sdata_oe_o) run <= run + 1'b1;
    else run <= '0;
  end

  always @(negedge bclk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!sdata_oe_o && !sdata_o); // R1
    end
  end

  AST_RESERVED_SILENT: assert property (@(negedge bclk) disable iff (!rst_n)
    ($past(mode) > 3'd4) |-> !sdata_oe_o); // R2

  AST_MSB_AFTER_EDGE: assert property (@(negedge bclk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n) && $past(mode) == 3'd0 &&
     $past(lrclk) != $past(lrclk, 2)) |-> (sdata_oe_o && run == 8'd0)); // R3

  AST_BURST_LIMIT: assert property (@(negedge bclk) disable iff (!rst_n)
    sdata_oe_o |-> (int'(run) < SAMPLE_W)); // R4

  AST_QUIET_ZERO: assert property (@(negedge bclk) disable iff (!rst_n)
    !sdata_oe_o |-> !sdata_o); // R9
endmodule

bind serial_slot_tx serial_slot_tx_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .mode(mode),
  .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o)
);

// File: tb/serial_slot_tx_test.sv
module serial_slot_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int FRAMES     = 3;

  logic        bclk = 1'b1;
  logic        rst_n = 1'b0;
  logic        lrclk = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [19:0] left_i = '0, right_i = '0;
  logic        sdata_o, sdata_oe_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  serial_slot_tx uut (
    .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .mode(mode),
    .left_i(left_i), .right_i(right_i), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o)
  );

  always #(CLK_PERIOD/2) bclk = ~bclk;

  function automatic logic [19:0] samp(int f, int m, bit right);
    case (f % 4)
      0: return right ? 20'h00001 : 20'h80000;
      1: return right ? 20'h00000 : 20'hFFFFF;
      default: return 20'((f * 238023 + m * 499 + (right ? 91357 : 0)) & 20'hFFFFF);
    endcase
  endfunction

  task automatic chk(string req, logic act_oe, logic act_d, logic exp_oe, logic exp_d);
    checks++;
    if (act_oe !== exp_oe || act_d !== exp_d) begin
      fails++;
      $display("FAIL %s: oe/data actual %b/%b expected %b/%b at %0t",
               req, act_oe, act_d, exp_oe, exp_d, $time);
    end
  endtask

  task automatic run_cfg(int m, int fbits);
    logic exp_oe, exp_d, idle;
    string req;
    idle = (m == 0);
    @(posedge bclk);
    rst_n = 1'b0;
    mode = 3'(m);
    lrclk = idle;
    #1;
    chk("R1 reset", sdata_oe_o, sdata_o, 1'b0, 1'b0);
    repeat (2) @(posedge bclk);
    rst_n = 1'b1;
    repeat (6) begin
      @(posedge bclk);
      chk("R1 idle", sdata_oe_o, sdata_o, 1'b0, 1'b0);
    end
    exp_oe = 1'b0; exp_d = 1'b0; req = "R1";
    for (int n = 0; n < FRAMES * fbits; n++) begin
      int f, q, b, s;
      logic [19:0] sl, sr, w;
      @(posedge bclk);
      chk(req, sdata_oe_o, sdata_o, exp_oe, exp_d);
      f = n / fbits; q = n % fbits;
      sl = samp(f, m, 1'b0); sr = samp(f, m, 1'b1);
      if (q == 0) begin left_i = sl; right_i = sr; end
      if (q == 5) begin left_i = ~sl; right_i = sr ^ 20'h5A5A5; end
      if (m == 0) lrclk = (q >= fbits / 2);
      else        lrclk = (q < fbits / 2);
      #1;
      chk("R8 no change between falling edges", sdata_oe_o, sdata_o, exp_oe, exp_d);
      if (m == 0) begin
        b = q % (fbits / 2);
        w = (q >= fbits / 2) ? sr : sl;
        exp_oe = (b < 20);
        exp_d = exp_oe ? w[19 - b] : 1'b0;
        req = (b < 20) ? "R3 R7 two-channel bit" : "R4 two-channel release";
      end else if (m <= 4) begin
        s = q / 32; b = q % 32;
        w = (s % 2) ? sr : sl;
        exp_oe = (q < 256) && (s / 2 == m - 1) && (b < 20);
        exp_d = exp_oe ? w[19 - b] : 1'b0;
        req = exp_oe ? "R5 R6 R7 slot bit" : "R6 R9 slot release";
      end else begin
        exp_oe = 1'b0; exp_d = 1'b0;
        req = "R2 reserved mode";
      end
    end
    @(posedge bclk);
    chk(req, sdata_oe_o, sdata_o, exp_oe, exp_d);
    rst_n = 1'b0;
    #1;
    chk("R1 reset mid-run", sdata_oe_o, sdata_o, 1'b0, 1'b0);
  endtask

  initial begin
    int i2s_ratios[6] = '{64, 128, 192, 256, 384, 512};
    foreach (i2s_ratios[k]) run_cfg(0, i2s_ratios[k]);
    for (int m = 1; m <= 4; m++) begin
      run_cfg(m, 256);
      run_cfg(m, 512);
    end
    run_cfg(5, 256);
    run_cfg(7, 128);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule